// File: doc/BRIEF.md
# Register-List Burst Master

This block is the bus-facing front end of a processor data port. It accepts one request at a time and converts it into AHB-Lite transfers. A request is one of three kinds. A plain data access is a single byte, halfword or word load or store. A register-list transfer takes a bitmask of up to sixteen registers, a base address and a direction. A fetch-style request is a single word read. A register-list transfer becomes one incrementing burst of word beats, one beat per selected register, taken from the lowest register index to the highest.

Each request produces one result. An accepted request ends with a one-cycle completion pulse. An illegal request ends with a one-cycle error pulse and never reaches the bus. Read data comes back beat by beat, tagged with the register it belongs to. Write data for a register-list store is fetched from the register file through an index/data lookup pair. Slave wait states on HREADY stretch both phases.

The controller has five states:
- `ST_IDLE` waits for a request. A legal request goes to `ST_ADDR`; an illegal one goes to `ST_REJECT`.
- `ST_ADDR` drives one address phase per beat. It stays there while HREADY is low or beats remain. When the last beat's address is accepted it goes to `ST_DRAIN`.
- `ST_DRAIN` holds the final data phase until HREADY is high, then goes to `ST_FINISH`.
- `ST_FINISH` raises the completion pulse and returns to `ST_IDLE`.
- `ST_REJECT` raises the error pulse and returns to `ST_IDLE`.

Top module: `regburst_master`

## Requirements
- R1: After reset and between requests, HTRANS is IDLE (2'b00), req_ready is 1, and done and err are 0.
- R2: A data request (req_kind=2'b00) makes exactly one NONSEQ (2'b10) transfer.
  - HBURST is INCR (3'b001) and HADDR is req_addr.
  - HSIZE follows req_size: 0 is byte, 1 is halfword, 2 is word.
  - A read returns the captured HRDATA word unchanged on rd_data, with rd_idx 0.
- R3: A fetch request (req_kind=2'b10) makes exactly one NONSEQ word read with HBURST SINGLE (3'b000), whatever req_write says.
- R4: A register-list request (req_kind=2'b01) makes as many beats as req_mask has bits set. Every beat has HSIZE word (3'b010) and HBURST INCR.
- R5: In a register-list burst, the first beat is NONSEQ and every later beat is SEQ. Beat k has address base + 4*k.
- R6: Beats serve the selected registers in ascending index order.
  - A read beat returns rd_valid with rd_idx set to that register's index.
  - A write beat presents the register's index on wr_reg_idx during its address phase. The value looked up there is driven on HWDATA in the following data phase.
- R7: The following requests are rejected: a register-list request with an empty mask, a register-list request with more than 14 bits set, a data request with req_size=3, and req_kind=2'b11. A rejected request gives a one-cycle err pulse, no transfer and no done pulse. A mask with exactly 14 bits set is accepted.
- R8: While HREADY is low during an address phase, HADDR and HTRANS hold their values. No beat is repeated or dropped.
- R9: done is high for exactly one cycle. That cycle directly follows the cycle in which the last data phase completes with HREADY high.
- R10: HBURST only ever carries SINGLE or INCR. Fixed-length and wrapping encodings never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 0 data, 1 register list, 2 fetch, 3 reserved |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Data access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Access address or burst base |
| req_mask | input | NREG | Register-list selection mask |
| req_wdata | input | DATA_W | Store data for a data request |
| wr_reg_idx | output | IDX_W | Register whose store data is being looked up |
| wr_reg_data | input | DATA_W | Register file value for wr_reg_idx |
| rd_valid | output | 1 | Read beat result valid |
| rd_idx | output | IDX_W | Register index of the read beat |
| rd_data | output | DATA_W | Read beat data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| haddr | output | ADDR_W | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB direction |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hwdata | output | DATA_W | AHB write data |
| hrdata | input | DATA_W | AHB read data |
| hready | input | 1 | AHB transfer ready |

## Verification
The bench drives register-list bursts with sparse masks, dense masks and a 14-register mask, both with and without periodic wait states. A design that walked the mask in the wrong direction, or indexed registers by beat number rather than register number, would return wrong rd_idx tags or store the wrong register values. A design that stepped the address during a wait state would skip memory words. The bench also sends masks of 0 and 15 bits, an illegal size and the reserved kind. A design that checked the limit with the wrong comparison would either start a burst or reject the legal 14-bit case. Single and fetch requests are checked for their HBURST encoding. The completion pulse is timed against the final data phase, so a pulse raised on the last address phase is caught.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_t;

    typedef enum logic [1:0] {
        K_DATA  = 2'b00,
        K_MULTI = 2'b01,
        K_FETCH = 2'b10,
        K_RSVD  = 2'b11
    } req_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DRAIN,
        ST_FINISH,
        ST_REJECT
    } fsm_t;

    localparam logic [2:0] BURST_SINGLE = 3'b000;
    localparam logic [2:0] BURST_INCR   = 3'b001;

endpackage

// File: rtl/regmask_scan.sv
module regmask_scan #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG),
    parameter int CNT_W = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0]  mask,
    output logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] first_idx
);
    always_comb begin
        count     = '0;
        first_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            count = count + CNT_W'(mask[i]);
            if (mask[i]) begin
                first_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/burst_req_check.sv
module burst_req_check
    import rbm_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int MAX_BEATS = 14,
    parameter int CNT_W     = $clog2(NREG + 1)
) (
    input  req_kind_t        kind,
    input  logic [1:0]       size,
    input  logic [NREG-1:0]  mask,
    output logic             legal,
    output logic [NREG-1:0]  beat_mask
);
    logic [CNT_W-1:0] bits_set;

    always_comb begin
        bits_set = '0;
        for (int i = 0; i < NREG; i++) begin
            bits_set = bits_set + CNT_W'(mask[i]);
        end
    end

    always_comb begin
        legal     = 1'b0;
        beat_mask = NREG'(1);
        unique case (kind)
            K_DATA:  legal = (size != 2'b11);
            K_FETCH: legal = 1'b1;
            K_MULTI: begin
                legal     = (bits_set != '0) && (bits_set <= CNT_W'(MAX_BEATS));
                beat_mask = mask;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/regburst_master.sv
module regburst_master
    import rbm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NREG      = 16,
    parameter int MAX_BEATS = 14,
    parameter int IDX_W     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NREG-1:0]   req_mask,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [IDX_W-1:0]  wr_reg_idx,
    input  logic [DATA_W-1:0] wr_reg_data,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready
);
    localparam int          BYTES   = DATA_W / 8;
    localparam int          CNT_W   = $clog2(NREG + 1);
    localparam logic [2:0]  SZ_WORD = 3'($clog2(BYTES));

    fsm_t              state, state_nx;
    req_kind_t         op_kind;
    logic              op_write;
    logic [1:0]        op_size;
    logic [DATA_W-1:0] op_wdata;
    logic [NREG-1:0]   rem_mask;
    logic [ADDR_W-1:0] cur_addr;
    logic              first_beat;
    logic              dp_valid, dp_write;
    logic [IDX_W-1:0]  dp_idx;
    logic [DATA_W-1:0] hwdata_q;
    logic              rd_valid_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [DATA_W-1:0] rd_data_q;

    logic              req_legal;
    logic [NREG-1:0]   req_beats;
    logic [CNT_W-1:0]  rem_cnt;
    logic [IDX_W-1:0]  cur_idx;
    logic              accept, addr_go, dp_done, last_beat;

    burst_req_check #(.NREG(NREG), .MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)) u_check (
        .kind      (req_kind_t'(req_kind)),
        .size      (req_size),
        .mask      (req_mask),
        .legal     (req_legal),
        .beat_mask (req_beats)
    );

    regmask_scan #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
        .mask      (rem_mask),
        .count     (rem_cnt),
        .first_idx (cur_idx)
    );

    assign accept    = (state == ST_IDLE) && req_valid && req_legal;
    assign addr_go   = (state == ST_ADDR) && hready;
    assign dp_done   = dp_valid && hready;
    assign last_beat = (rem_cnt == CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = req_legal ? ST_ADDR : ST_REJECT;
            ST_ADDR:   if (hready && last_beat) state_nx = ST_DRAIN;
            ST_DRAIN:  if (hready) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request capture and beat walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_kind    <= K_DATA;
            op_write   <= 1'b0;
            op_size    <= 2'b00;
            op_wdata   <= '0;
            rem_mask   <= '0;
            cur_addr   <= '0;
            first_beat <= 1'b0;
            dp_valid   <= 1'b0;
            dp_write   <= 1'b0;
            dp_idx     <= '0;
            hwdata_q   <= '0;
        end else begin
            if (accept) begin
                op_kind    <= req_kind_t'(req_kind);
                op_write   <= req_write && (req_kind_t'(req_kind) != K_FETCH);
                op_size    <= req_size;
                op_wdata   <= req_wdata;
                rem_mask   <= req_beats;
                cur_addr   <= req_addr;
                first_beat <= 1'b1;
            end else if (addr_go) begin
                rem_mask   <= rem_mask & ~(NREG'(1) << cur_idx);
                cur_addr   <= cur_addr + ADDR_W'(BYTES);
                first_beat <= 1'b0;
            end
            if (addr_go) begin
                dp_valid <= 1'b1;
                dp_write <= op_write;
                dp_idx   <= cur_idx;
                hwdata_q <= (op_kind == K_MULTI) ? wr_reg_data : op_wdata;
            end else if (dp_done) begin
                dp_valid <= 1'b0;
            end
        end
    end

    // Read-beat capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_idx_q   <= '0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= dp_done && !dp_write;
            if (dp_done) begin
                rd_idx_q  <= dp_idx;
                rd_data_q <= hrdata;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        done       = (state == ST_FINISH);
        err        = (state == ST_REJECT);
        htrans     = TR_IDLE;
        haddr      = '0;
        hwrite     = 1'b0;
        if (state == ST_ADDR) begin
            htrans = first_beat ? TR_NONSEQ : TR_SEQ;
            haddr  = cur_addr;
            hwrite = op_write;
        end
        hsize      = (op_kind == K_DATA) ? {1'b0, op_size} : SZ_WORD;
        hburst     = (op_kind == K_FETCH) ? BURST_SINGLE : BURST_INCR;
        hwdata     = hwdata_q;
        wr_reg_idx = cur_idx;
        rd_valid   = rd_valid_q;
        rd_idx     = rd_idx_q;
        rd_data    = rd_data_q;
    end

    // R1: no transfer outside a request
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (htrans == TR_IDLE));

    // R4: continuation beats are word-sized incrementing beats
    p_seq_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> (hsize == SZ_WORD && hburst == BURST_INCR));

    // R5: a burst opens with NONSEQ
    p_first_nonseq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE && $past(htrans) == TR_IDLE) |-> (htrans == TR_NONSEQ));

    // R5: address steps one word after an accepted beat
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hready) && htrans == TR_SEQ) |-> (haddr == $past(haddr) + ADDR_W'(BYTES)));

    // R6: read tags rise within a burst
    p_rd_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_idx > $past(rd_idx)));

    // R7: rejection has no bus activity
    p_err_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (htrans == TR_IDLE && !done));

    // R8: address phase held during a wait state
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE && !hready) |=> ($stable(haddr) && $stable(htrans)));

    // R9: completion follows the final data phase, one cycle wide
    p_done_after_dp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(dp_valid) && $past(hready)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: only SINGLE or INCR burst encodings
    p_burst_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hburst == BURST_SINGLE || hburst == BURST_INCR));

endmodule

// File: tb/regburst_master_tb_top.sv
module regburst_master_tb_top;
    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [15:0] req_mask = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  wr_reg_idx;
    logic [31:0] wr_reg_data;
    logic        rd_valid;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        done, err;
    logic [31:0] haddr, hwdata, hrdata;
    logic [1:0]  htrans;
    logic        hwrite, hready;
    logic [2:0]  hsize, hburst;

    always #4 clk = ~clk;

    regburst_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
        .wr_reg_idx(wr_reg_idx), .wr_reg_data(wr_reg_data),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
        .done(done), .err(err), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
    );

    function automatic logic [31:0] memf(input int w);
        return 32'hBEE00000 + 32'(w) * 32'h00000101;
    endfunction
    function automatic logic [31:0] regval(input int i);
        return 32'h7E000000 + 32'(i) * 32'h00110011;
    endfunction

    // slave model
    logic [31:0] mem [64];
    logic [31:0] cyc = 0;
    logic        stall_en = 1'b0;
    logic        sp_pend = 1'b0, sp_wr = 1'b0;
    logic [31:0] sp_addr = '0;
    assign hready      = !(stall_en && (cyc % 3 == 2));
    assign hrdata      = mem[sp_addr[7:2]];
    assign wr_reg_data = regval(int'(wr_reg_idx));

    // logs
    logic [31:0] la_addr [64];
    logic [1:0]  la_trans [64];
    logic [2:0]  la_size [64], la_burst [64];
    logic        la_wr [64];
    int          log_n = 0, rl_n = 0, done_n = 0, err_n = 0, hold_bad = 0;
    logic [3:0]  rl_idx [64];
    logic [31:0] rl_data [64];
    logic [31:0] dp_end_cyc = 0, done_cyc = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] held_addr = '0;
    logic [1:0]  held_trans = '0;

    initial for (int w = 0; w < 64; w++) mem[w] = memf(w);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (sp_pend && hready) begin
            dp_end_cyc <= cyc;
            if (sp_wr) mem[sp_addr[7:2]] <= hwdata;
        end
        if (hready) begin
            sp_pend <= htrans[1];
            sp_addr <= haddr;
            sp_wr   <= hwrite;
        end
        if (rst_n && hready && htrans[1]) begin
            la_addr[log_n % 64] <= haddr; la_trans[log_n % 64] <= htrans;
            la_size[log_n % 64] <= hsize; la_burst[log_n % 64] <= hburst;
            la_wr[log_n % 64]   <= hwrite;
            log_n <= log_n + 1;
        end
        if (rd_valid) begin
            rl_idx[rl_n % 64] <= rd_idx; rl_data[rl_n % 64] <= rd_data;
            rl_n <= rl_n + 1;
        end
        if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
        if (err) err_n <= err_n + 1;
        if (prev_wait && (haddr != held_addr || htrans != held_trans)) hold_bad <= hold_bad + 1;
        prev_wait  <= (htrans != 2'b00) && !hready;
        held_addr  <= haddr;
        held_trans <= htrans;
    end

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] kind, input logic wr, input logic [1:0] size,
                         input logic [31:0] addr, input logic [15:0] mask, input logic [31:0] wd);
        int d0 = done_n, e0 = err_n;
        @(negedge clk);
        req_kind = kind; req_write = wr; req_size = size;
        req_addr = addr; req_mask = mask; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 300; t++) begin
            if (done_n != d0 || err_n != e0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(htrans == 2'b00, "R1", "htrans idle", 32'(htrans), 0);
        chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
        chk(!done && !err, "R1", "done/err low", {30'd0, done, err}, 0);
    endtask

    task automatic t_single(input logic wr, input logic [1:0] size, input logic [31:0] addr,
                            input logic [31:0] wd);
        int l0 = log_n, r0 = rl_n, d0 = done_n;
        issue(2'b00, wr, size, addr, 16'h0, wd);
        chk(log_n - l0 == 1, "R2", "one transfer", 32'(log_n - l0), 1);
        chk(la_trans[l0 % 64] == 2'b10, "R2", "nonseq", 32'(la_trans[l0 % 64]), 2);
        chk(la_burst[l0 % 64] == 3'b001, "R2", "incr burst", 32'(la_burst[l0 % 64]), 1);
        chk(la_size[l0 % 64] == {1'b0, size}, "R2", "hsize", 32'(la_size[l0 % 64]), 32'(size));
        chk(la_addr[l0 % 64] == addr, "R2", "haddr", la_addr[l0 % 64], addr);
        chk(done_n - d0 == 1, "R9", "one done", 32'(done_n - d0), 1);
        if (wr) begin
            chk(mem[addr[7:2]] == wd, "R2", "stored word", mem[addr[7:2]], wd);
        end else begin
            chk(rl_n - r0 == 1, "R2", "one read beat", 32'(rl_n - r0), 1);
            chk(rl_data[r0 % 64] == memf(int'(addr[7:2])), "R2", "read data",
                rl_data[r0 % 64], memf(int'(addr[7:2])));
            chk(rl_idx[r0 % 64] == 4'd0, "R2", "read idx", 32'(rl_idx[r0 % 64]), 0);
        end
    endtask

    task automatic t_fetch(input logic [31:0] addr);
        int l0 = log_n, r0 = rl_n;
        issue(2'b10, 1'b1, 2'b00, addr, 16'h0, 32'h0);
        chk(log_n - l0 == 1, "R3", "one transfer", 32'(log_n - l0), 1);
        chk(la_burst[l0 % 64] == 3'b000, "R3", "single burst", 32'(la_burst[l0 % 64]), 0);
        chk(la_size[l0 % 64] == 3'b010, "R3", "word size", 32'(la_size[l0 % 64]), 2);
        chk(la_wr[l0 % 64] == 1'b0, "R3", "read only", 32'(la_wr[l0 % 64]), 0);
        chk(la_trans[l0 % 64] == 2'b10, "R3", "nonseq", 32'(la_trans[l0 % 64]), 2);
        chk(rl_data[r0 % 64] == memf(int'(addr[7:2])), "R3", "fetch data",
            rl_data[r0 % 64], memf(int'(addr[7:2])));
    endtask

    task automatic t_multi(input logic wr, input logic [15:0] mask, input logic [31:0] base,
                           input logic stall);
        int l0 = log_n, r0 = rl_n, d0 = done_n, h0 = hold_bad, k = 0;
        stall_en = stall;
        issue(2'b01, wr, 2'b00, base, mask, 32'h0);
        stall_en = 1'b0;
        chk(log_n - l0 == $countones(mask), "R4", "beat count", 32'(log_n - l0), 32'($countones(mask)));
        for (int i = 0; i < NREG; i++) begin
            if (mask[i]) begin
                int e = (l0 + k) % 64;
                chk(la_trans[e] == (k == 0 ? 2'b10 : 2'b11), "R5", "beat trans",
                    32'(la_trans[e]), (k == 0 ? 2 : 3));
                chk(la_addr[e] == base + 32'(4 * k), "R5", "beat addr", la_addr[e], base + 32'(4 * k));
                chk(la_size[e] == 3'b010 && la_burst[e] == 3'b001, "R4", "word incr",
                    {26'd0, la_size[e], la_burst[e]}, 32'h11);
                if (wr) begin
                    chk(mem[6'((base >> 2) + 32'(k))] == regval(i), "R6", "stored reg",
                        mem[6'((base >> 2) + 32'(k))], regval(i));
                end else begin
                    chk(rl_idx[(r0 + k) % 64] == 4'(i), "R6", "read idx",
                        32'(rl_idx[(r0 + k) % 64]), 32'(i));
                    chk(rl_data[(r0 + k) % 64] == memf(int'((base >> 2) + 32'(k))), "R6", "read data",
                        rl_data[(r0 + k) % 64], memf(int'((base >> 2) + 32'(k))));
                end
                k++;
            end
        end
        if (!wr) chk(rl_n - r0 == k, "R8", "read beat count", 32'(rl_n - r0), 32'(k));
        chk(hold_bad == h0, "R8", "hold during wait", 32'(hold_bad - h0), 0);
        chk(done_n - d0 == 1, "R9", "one done", 32'(done_n - d0), 1);
        chk(done_cyc == dp_end_cyc + 1, "R9", "done timing", done_cyc, dp_end_cyc + 1);
    endtask

    task automatic t_reject(input logic [1:0] kind, input logic [1:0] size, input logic [15:0] mask);
        int l0 = log_n, d0 = done_n, e0 = err_n;
        issue(kind, 1'b0, size, 32'h40, mask, 32'h0);
        chk(err_n - e0 == 1, "R7", "one err pulse", 32'(err_n - e0), 1);
        chk(log_n == l0, "R7", "no transfer", 32'(log_n - l0), 0);
        chk(done_n == d0, "R7", "no done", 32'(done_n - d0), 0);
        chk(htrans == 2'b00 && req_ready, "R1", "idle after reject", 32'(htrans), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_single(1'b0, 2'b00, 32'h0000_0011, 32'h0);
        t_single(1'b0, 2'b01, 32'h0000_0022, 32'h0);
        t_single(1'b1, 2'b10, 32'h0000_00F0, 32'hCAFE_1234);
        t_fetch(32'h0000_0084);
        t_multi(1'b0, 16'b0000_0000_1001_0101, 32'h0000_0010, 1'b0);
        t_multi(1'b0, 16'b1100_0011_0000_1010, 32'h0000_0030, 1'b1);
        t_multi(1'b1, 16'b0000_0000_0000_0001, 32'h0000_00C0, 1'b0);
        t_multi(1'b1, 16'hFFFC, 32'h0000_0088, 1'b1);
        t_multi(1'b0, 16'h3FFF, 32'h0000_0040, 1'b0);
        t_reject(2'b01, 2'b00, 16'h0000);
        t_reject(2'b01, 2'b00, 16'h7FFF);
        t_reject(2'b00, 2'b11, 16'h0000);
        t_reject(2'b11, 2'b10, 16'h0001);
        for (int e = 0; e < log_n && e < 64; e++)
            chk(la_burst[e] == 3'b000 || la_burst[e] == 3'b001, "R10", "burst encoding",
                32'(la_burst[e]), 1);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule